// File: doc/BRIEF.md
# Dual-Mode Serial Clock Divider

This block derives the serial clock of an SPI master from a faster module clock. A single configuration word holds two divisor fields and a mode bit. In linear mode the output runs at the module clock divided by an even number, 2·(N+1). In exponential mode it runs at the module clock divided by a power of two, 2^(M+1). Software normally picks linear mode and uses exponential mode only when the required divisor is too large for the linear field. Working out the field values from a target rate is left to software.

The output has a 50% duty cycle. Next to the clock, the block drives two single-cycle strobes for the shift logic. The leading strobe marks the clock leaving its idle level. The trailing strobe marks the clock returning to it. When the enable is low, the clock is parked at a programmable idle level. Configuration and polarity changes are applied only at safe points, so the clock never shows a shortened pulse.

Top module: `spi_clkgen_dual`

## Requirements
- R1: With cfg_i bit 12 = 1 (linear mode), each half period of sclk_o lasts N+1 module-clock cycles, where N = cfg_i[7:0]. The full period is therefore 2·(N+1), and N = 255 gives a half period of 256 cycles.
- R2: With cfg_i bit 12 = 0 (exponential mode), each half period lasts 2^M module-clock cycles, where M = cfg_i[11:8]. The full period is therefore 2^(M+1), and M = 15 gives a half period of 32768 cycles.
- R3: Linear N = 0 is legal. In that mode sclk_o toggles on every module-clock edge, which is half the module clock rate.
- R4: High and low phases of sclk_o are the same length (50% duty).
- R5: While en_i = 0, the internal count is held at zero, sclk_o sits at the idle level and no strobe fires. After en_i rises, the first toggle comes exactly one full half period later.
- R6: A cfg_i change while enabled does not shorten or stretch the half period in progress. The new divisor is used from the next half-period boundary on. While disabled, a cfg_i change takes effect on the next edge.
- R7: lead_o is high for exactly the one cycle in which sclk_o first shows the non-idle level. trail_o is high for exactly the one cycle in which sclk_o first shows the idle level again.
- R8: The idle level follows cpol_i while disabled. With cpol_i = 1, sclk_o idles high and lead_o marks a falling edge. A change of cpol_i while enabled is ignored until the divider is disabled.
- R9: lead_o and trail_o are never high together. While enabled, sclk_o changes only in a cycle with one of the two strobes high.
- R10: During reset, sclk_o, lead_o and trail_o are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Module clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_i | input | 13 | Divider word: {mode, M[3:0], N[7:0]} |
| en_i | input | 1 | Run the divider when high |
| cpol_i | input | 1 | Idle level of the serial clock |
| sclk_o | output | 1 | Serial clock |
| lead_o | output | 1 | One-cycle strobe on the edge leaving idle |
| trail_o | output | 1 | One-cycle strobe on the edge returning to idle |

## Verification
On every cycle, the assertions check the following:
- the disabled state: parked clock, zero count and no strobes;
- that strobes are exclusive and match each change of sclk_o;
- that each strobe points in the right direction relative to the latched polarity;
- that the count always stays below the active half-period length.

Some behaviours can only be shown by the bench's scoreboard scenarios, which compare the exact cycle of every clock edge against times predicted from the field values:
- the actual divisor chosen in each mode, including N = 0, N = 255 and M = 15;
- how a mid-period configuration change is deferred to the next boundary;
- that a polarity change while running is ignored.

// File: rtl/spi_clkgen_pkg.sv
package spi_clkgen_pkg;

    // Width needed for a half-period length: linear mode reaches 2**lin_w,
    // exponential mode reaches 2**(2**exp_w - 1).
    function automatic int cnt_width(input int lin_w, input int exp_w);
        int lin_bits;
        int exp_bits;
        lin_bits = lin_w + 1;
        exp_bits = 1 << exp_w;
        return (lin_bits > exp_bits) ? lin_bits : exp_bits;
    endfunction

    typedef enum logic {
        MODE_EXP = 1'b0,
        MODE_LIN = 1'b1
    } div_mode_e;

endpackage

// File: rtl/spi_clkgen_cfg.sv
// Shadow copy of the divider setting. It holds the active half-period length
// and the latched idle level, and reloads only at safe points.
module spi_clkgen_cfg
    import spi_clkgen_pkg::*;
#(
    parameter int LIN_W = 8,
    parameter int EXP_W = 4,
    parameter int CNT_W = 16,
    localparam int CFG_W = LIN_W + EXP_W + 1,
    localparam int SEL_BIT = LIN_W + EXP_W
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [CFG_W-1:0] cfg_i,
    input  logic             en_i,
    input  logic             tick_i,
    input  logic             cpol_i,
    output logic [CNT_W-1:0] half_o,
    output logic             pol_o
);

    typedef struct packed {
        logic [CNT_W-1:0] half;
        logic             pol;
    } cfg_state_t;

    cfg_state_t       s_d, s_q;
    div_mode_e        mode_w;
    logic [CNT_W-1:0] lin_len_w;
    logic [CNT_W-1:0] exp_len_w;

    always_comb begin
        mode_w    = div_mode_e'(cfg_i[SEL_BIT]);
        lin_len_w = CNT_W'(cfg_i[LIN_W-1:0]) + CNT_W'(1);
        exp_len_w = CNT_W'(1) << cfg_i[LIN_W +: EXP_W];

        s_d = s_q;
        // new divisor: while idle, or at the end of a half period
        if (!en_i || tick_i) begin
            s_d.half = (mode_w == MODE_LIN) ? lin_len_w : exp_len_w;
        end
        // polarity only moves while the divider is stopped
        if (!en_i) begin
            s_d.pol = cpol_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q.half <= CNT_W'(1);
            s_q.pol  <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign half_o = s_q.half;
    assign pol_o  = s_q.pol;

endmodule

// File: rtl/spi_clkgen_cnt.sv
// Half-period counter: counts 0 .. half-1 while enabled and flags the last step.
module spi_clkgen_cnt #(
    parameter int CNT_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             en_i,
    input  logic [CNT_W-1:0] half_i,
    output logic             tick_o,
    output logic [CNT_W-1:0] cnt_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t       s_d, s_q;
    logic [CNT_W-1:0] last_w;
    logic             tick_w;

    always_comb begin
        last_w = half_i - CNT_W'(1);
        tick_w = en_i && (s_q.cnt == last_w);

        s_d = s_q;
        if (!en_i || tick_w) begin
            s_d.cnt = '0;
        end else begin
            s_d.cnt = s_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q.cnt <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign tick_o = tick_w;
    assign cnt_o  = s_q.cnt;

endmodule

// File: rtl/spi_clkgen_out.sv
// Output stage: serial clock flop and the two edge strobes. The strobes are
// registered so that they line up with the cycle in which sclk shows its new level.
module spi_clkgen_out (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic en_i,
    input  logic tick_i,
    input  logic pol_i,
    input  logic cpol_i,
    output logic sclk_o,
    output logic lead_o,
    output logic trail_o
);

    typedef struct packed {
        logic sclk;
        logic lead;
        logic trail;
    } out_state_t;

    out_state_t s_d, s_q;
    logic       at_idle_w;

    always_comb begin
        at_idle_w = (s_q.sclk == pol_i);

        s_d       = s_q;
        s_d.lead  = 1'b0;
        s_d.trail = 1'b0;
        if (!en_i) begin
            s_d.sclk = cpol_i;
        end else if (tick_i) begin
            s_d.sclk  = ~s_q.sclk;
            s_d.lead  = at_idle_w;
            s_d.trail = ~at_idle_w;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign sclk_o  = s_q.sclk;
    assign lead_o  = s_q.lead;
    assign trail_o = s_q.trail;

endmodule

// File: rtl/spi_clkgen_dual.sv
// Serial clock divider with linear and power-of-two modes.
module spi_clkgen_dual
    import spi_clkgen_pkg::*;
#(
    parameter int LIN_W = 8,
    parameter int EXP_W = 4,
    localparam int CFG_W = LIN_W + EXP_W + 1,
    localparam int CNT_W = cnt_width(LIN_W, EXP_W)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [CFG_W-1:0] cfg_i,
    input  logic             en_i,
    input  logic             cpol_i,
    output logic             sclk_o,
    output logic             lead_o,
    output logic             trail_o
);

    logic [CNT_W-1:0] half_w;
    logic [CNT_W-1:0] cnt_w;
    logic             tick_w;
    logic             pol_w;

    spi_clkgen_cfg #(
        .LIN_W(LIN_W),
        .EXP_W(EXP_W),
        .CNT_W(CNT_W)
    ) u_cfg (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .cfg_i (cfg_i),
        .en_i  (en_i),
        .tick_i(tick_w),
        .cpol_i(cpol_i),
        .half_o(half_w),
        .pol_o (pol_w)
    );

    spi_clkgen_cnt #(
        .CNT_W(CNT_W)
    ) u_cnt (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .en_i  (en_i),
        .half_i(half_w),
        .tick_o(tick_w),
        .cnt_o (cnt_w)
    );

    spi_clkgen_out u_out (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .en_i   (en_i),
        .tick_i (tick_w),
        .pol_i  (pol_w),
        .cpol_i (cpol_i),
        .sclk_o (sclk_o),
        .lead_o (lead_o),
        .trail_o(trail_o)
    );

endmodule

// File: rtl/spi_clkgen_chk.sv
module spi_clkgen_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             en_i,
    input logic             cpol_i,
    input logic             sclk_o,
    input logic             lead_o,
    input logic             trail_o,
    input logic [CNT_W-1:0] cnt_i,
    input logic [CNT_W-1:0] half_i,
    input logic             pol_i
);

    // R5
    idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !en_i |=> (sclk_o == $past(cpol_i)) && !lead_o && !trail_o);

    // R5
    cnt_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !en_i |=> (cnt_i == '0));

    // R9
    excl_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(lead_o && trail_o));

    // R9
    edge_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        en_i |=> ((sclk_o != $past(sclk_o)) == (lead_o || trail_o)));

    // R4
    cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cnt_i < half_i);

    // R7
    lead_dir_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        lead_o |-> (sclk_o != pol_i));

    // R7
    trail_dir_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        trail_o |-> (sclk_o == pol_i));

endmodule

bind spi_clkgen_dual spi_clkgen_chk #(.CNT_W(CNT_W)) u_chk (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_i),
    .cpol_i (cpol_i),
    .sclk_o (sclk_o),
    .lead_o (lead_o),
    .trail_o(trail_o),
    .cnt_i  (cnt_w),
    .half_i (half_w),
    .pol_i  (pol_w)
);

// File: tb/spi_clkgen_dual_test.sv
`timescale 1ns/1ps
module spi_clkgen_dual_test;

    localparam int CFG_W = 13;

    typedef struct {
        int    at;
        bit    lvl;
        bit    ld;
        bit    tr;
        string req;
    } ev_t;

    logic             clk = 1'b0;
    logic             rst_ni = 1'b0;
    logic [CFG_W-1:0] cfg = '0;
    logic             en = 1'b0;
    logic             cpol = 1'b0;
    logic             sclk, lead, trail;

    ev_t exp_q[$];
    int  n_chk = 0;
    int  n_bad = 0;
    bit  done = 1'b0;

    always #4 clk = ~clk;

    spi_clkgen_dual uut (
        .clk_i  (clk),
        .rst_ni (rst_ni),
        .cfg_i  (cfg),
        .en_i   (en),
        .cpol_i (cpol),
        .sclk_o (sclk),
        .lead_o (lead),
        .trail_o(trail)
    );

    function automatic logic [CFG_W-1:0] mk(input bit lin, input int m, input int n);
        return {lin, 4'(m), 8'(n)};
    endfunction

    function automatic int half_of(input logic [CFG_W-1:0] c);
        return c[12] ? (int'(c[7:0]) + 1) : (1 << c[11:8]);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // Monitor: every sclk change or strobe while enabled is compared to the queue.
    int ecnt = 0;
    bit prev = 1'b0;
    always @(posedge clk) begin
        #1;
        if (!rst_ni) begin
            ecnt = 0;
            prev = sclk;
        end else begin
            if (en) ecnt++;
            else ecnt = 0;
            if (!en && (lead || trail)) begin
                check(1'b0, "R5 strobe while disabled", {30'd0, lead, trail}, 0);
            end else if (en && (sclk !== prev || lead || trail)) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R9 unexpected edge at", ecnt, -1);
                end else begin
                    ev_t e;
                    e = exp_q.pop_front();
                    check(e.at == ecnt, {e.req, " edge time"}, ecnt, e.at);
                    check({sclk, lead, trail} == {e.lvl, e.ld, e.tr},
                          {e.req, " level/lead/trail"},
                          int'({sclk, lead, trail}), int'({e.lvl, e.ld, e.tr}));
                end
            end
            prev = sclk;
        end
    end

    // Driver: predicts every edge of a run, then runs it.
    task automatic run(input logic [CFG_W-1:0] ca, input logic [CFG_W-1:0] cb,
                       input int chg, input int ntog, input bit pol,
                       input bit flip, input string req);
        int ha;
        int hb;
        int t;
        ha = half_of(ca);
        hb = half_of(cb);
        t  = 0;
        @(negedge clk);
        cfg  = ca;
        cpol = pol;
        en   = 1'b0;
        @(negedge clk);
        for (int k = 1; k <= ntog; k++) begin
            ev_t e;
            t += (k == 1) ? ha : ((chg > 0) ? hb : ha);
            e.at  = t;
            e.lvl = pol ^ k[0];
            e.ld  = k[0];
            e.tr  = ~k[0];
            e.req = req;
            exp_q.push_back(e);
        end
        en = 1'b1;
        for (int e = 1; e <= t; e++) begin
            @(negedge clk);
            if (chg > 0 && e == chg) begin
                cfg = cb;
                if (flip) cpol = ~pol;
            end
        end
        en   = 1'b0;
        cpol = pol;
        @(negedge clk);
        @(negedge clk);
        check(exp_q.size() == 0, {req, " missing edges"}, exp_q.size(), 0);
        exp_q.delete();
        check(sclk == pol, {req, " R5 idle after run"}, int'(sclk), int'(pol));
    endtask

    initial begin
        repeat (2) @(posedge clk);
        #1;
        // R10
        check({sclk, lead, trail} == 3'b000, "R10 reset outputs", int'({sclk, lead, trail}), 0);
        @(negedge clk);
        rst_ni = 1'b1;

        // R8 idle level follows cpol while disabled
        cpol = 1'b1;
        repeat (3) @(negedge clk);
        check(sclk == 1'b1, "R8 idle high", int'(sclk), 1);
        cpol = 1'b0;
        repeat (2) @(negedge clk);
        check(sclk == 1'b0 && !lead && !trail, "R5 idle low", int'(sclk), 0);

        run(mk(1, 7, 3), mk(1, 7, 3), 0, 4, 1'b0, 1'b0, "R1 R4 R5 R7 linear N=3");
        run(mk(1, 0, 0), mk(1, 0, 0), 0, 6, 1'b0, 1'b0, "R3 R9 linear N=0");
        run(mk(0, 2, 200), mk(0, 2, 200), 0, 4, 1'b1, 1'b0, "R2 R8 exp M=2 idle high");
        run(mk(1, 0, 255), mk(1, 0, 255), 0, 2, 1'b0, 1'b0, "R1 linear N=255");
        run(mk(1, 3, 9), mk(0, 1, 0), 4, 4, 1'b0, 1'b0, "R6 change mid period");
        run(mk(1, 0, 2), mk(1, 0, 2), 2, 4, 1'b0, 1'b1, "R8 cpol ignored while enabled");
        run(mk(0, 15, 0), mk(0, 15, 0), 0, 2, 1'b1, 1'b0, "R2 exp M=15");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule